// File: doc/BRIEF.md
# Per-line GPIO interrupt event detector

This block watches every input line of one GPIO bank and records, per line, whether the event chosen for that line has occurred. A 3-bit event-select value for each line comes from the bank's configuration registers. It selects falling edge, rising edge, either edge, low level or high level. Detected events are latched into a status word. An enable mask, kept through separate set and clear locations on a 32-bit register bus, decides which status bits reach the single interrupt output of the bank.

Software handles an interrupt by reading the status word, and that read also empties it, so no acknowledge write exists. A level event keeps reasserting its status bit for as long as the level lasts, so it comes back after the clearing read. An edge event is recorded once. Line inputs are taken as already synchronous to the clock, without glitch filtering.

Top module: `gpio_evt_bank`

## Requirements
- R1: After reset the enable mask and the status word read as zero and `irq` is low.
- R2: A write to offset 0x20 ORs the ones of the write data into the enable mask, which reads back at offset 0x28; any offset other than 0x28 and 0x2C reads as zero.
- R3: A write to offset 0x24 clears the enable-mask bits where the write data has ones and leaves the others unchanged.
- R4: With event select 0 (falling edge), a line's status bit is set only when the line goes from 1 to 0.
- R5: With event select 1 (rising edge), a line's status bit is set only when the line goes from 0 to 1, once per transition.
- R6: With event select 2 (either edge), a line's status bit is set on every change of the line.
- R7: With event select 3 (low level) or 4 (high level), the status bit is set on every cycle the line is at that level, so it reappears after a clearing read while the level lasts.
- R8: Event select values 5, 6 and 7 never set a status bit.
- R9: A read of offset 0x2C returns the status word and clears it at the same clock edge; an event detected in the cycle of that read stays set.
- R10: Status bits are set whether or not the line is enabled, and `irq` is high exactly when some line has both its status bit and its enable bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | AW (8) | Byte offset of the access |
| reg_wdata | input | DW (32) | Write data |
| reg_rdata | output | DW (32) | Read data, valid in the cycle of the read strobe |
| line_in | input | NLINES (32) | Synchronous line levels |
| evt_sel | input | 3*NLINES (96) | Event select per line, line n in bits 3n+2..3n |
| irq | output | 1 | Combined bank interrupt |

## Verification
A line change driven before a clock edge is compared with its previous sample at that edge, so the status bit is visible on the read data in the cycle after that edge. Read data is combinational on the current registers and is sampled in the cycle of the read strobe; the clear takes effect at the edge that ends that cycle. Mask writes change `irq` one edge after the write strobe. The bench drives every input at the falling clock edge and samples just after it. It counts edges so that each expected value is compared in exactly the cycle it falls due. The sweep over all eight event-select codes and every pair of old and new line levels computes the expected status word from the code rules for each line.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    EV_FALL = 3'd0,
    EV_RISE = 3'd1,
    EV_BOTH = 3'd2,
    EV_LOW  = 3'd3,
    EV_HIGH = 3'd4
  } evt_kind_e;

  localparam int OFF_EN_SET = 'h20;
  localparam int OFF_EN_CLR = 'h24;
  localparam int OFF_EN_VAL = 'h28;
  localparam int OFF_STATUS = 'h2C;

endpackage

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_evt_pkg::*;
#(
  parameter int NLINES = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NLINES-1:0]       line_in,
  input  logic [SEL_W*NLINES-1:0] evt_sel,
  output logic [NLINES-1:0]       hit
);

  logic [NLINES-1:0] prev_q, prev_d;
  logic              primed_q, primed_d;

  // next state: previous sample of each line, edges valid after first sample
  always_comb begin
    prev_d   = line_in;
    primed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= prev_d;
      primed_q <= primed_d;
    end
  end

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [SEL_W-1:0] sel;
    logic             rise, fall, h;

    assign sel  = evt_sel[g*SEL_W +: SEL_W];
    assign rise = primed_q &  line_in[g] & ~prev_q[g];
    assign fall = primed_q & ~line_in[g] &  prev_q[g];

    always_comb begin
      case (sel)
        EV_FALL: h = fall;
        EV_RISE: h = rise;
        EV_BOTH: h = rise | fall;
        EV_LOW:  h = ~line_in[g];
        EV_HIGH: h = line_in[g];
        default: h = 1'b0;
      endcase
    end

    assign hit[g] = h;
  end

endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
  import gpio_evt_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int DW     = 32,
  parameter int AW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic [NLINES-1:0] hit,
  output logic [DW-1:0]     reg_rdata,
  output logic [NLINES-1:0] mask_q,
  output logic [NLINES-1:0] status_q
);

  localparam logic [AW-1:0] A_SET = AW'(OFF_EN_SET);
  localparam logic [AW-1:0] A_CLR = AW'(OFF_EN_CLR);
  localparam logic [AW-1:0] A_VAL = AW'(OFF_EN_VAL);
  localparam logic [AW-1:0] A_STS = AW'(OFF_STATUS);

  logic              set_wr, clr_wr, sts_rd;
  logic              mask_en, status_en;
  logic [NLINES-1:0] mask_d, status_d, wbits;

  assign wbits  = reg_wdata[NLINES-1:0];
  assign set_wr = reg_wr_en & (reg_addr == A_SET);
  assign clr_wr = reg_wr_en & (reg_addr == A_CLR);
  assign sts_rd = reg_rd_en & (reg_addr == A_STS);

  always_comb begin
    mask_en   = set_wr | clr_wr;
    mask_d    = mask_q;
    if (set_wr) mask_d = mask_q | wbits;
    if (clr_wr) mask_d = mask_q & ~wbits;

    status_en = sts_rd | (|hit);
    status_d  = (sts_rd ? '0 : status_q) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      status_q <= '0;
    end else begin
      if (mask_en)   mask_q   <= mask_d;
      if (status_en) status_q <= status_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd_en) begin
      if (reg_addr == A_VAL) reg_rdata = DW'(mask_q);
      if (reg_addr == A_STS) reg_rdata = DW'(status_q);
    end
  end

endmodule

// File: rtl/gpio_evt_irq_merge.sv
module gpio_evt_irq_merge #(
  parameter int NLINES = 32
) (
  input  logic [NLINES-1:0] status_q,
  input  logic [NLINES-1:0] mask_q,
  output logic              irq
);

  assign irq = |(status_q & mask_q);

endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank
  import gpio_evt_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int DW     = 32,
  parameter int AW     = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr_en,
  input  logic                    reg_rd_en,
  input  logic [AW-1:0]           reg_addr,
  input  logic [DW-1:0]           reg_wdata,
  output logic [DW-1:0]           reg_rdata,
  input  logic [NLINES-1:0]       line_in,
  input  logic [SEL_W*NLINES-1:0] evt_sel,
  output logic                    irq
);

  logic [NLINES-1:0] hit, mask_q, status_q;

  gpio_evt_detect #(.NLINES(NLINES)) detect_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_in (line_in),
    .evt_sel (evt_sel),
    .hit     (hit)
  );

  gpio_evt_regs #(.NLINES(NLINES), .DW(DW), .AW(AW)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .hit       (hit),
    .reg_rdata (reg_rdata),
    .mask_q    (mask_q),
    .status_q  (status_q)
  );

  gpio_evt_irq_merge #(.NLINES(NLINES)) merge_i (
    .status_q (status_q),
    .mask_q   (mask_q),
    .irq      (irq)
  );

endmodule

// File: rtl/gpio_evt_bank_chk.sv
module gpio_evt_bank_chk
  import gpio_evt_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int DW     = 32,
  parameter int AW     = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    reg_wr_en,
  input logic                    reg_rd_en,
  input logic [AW-1:0]           reg_addr,
  input logic [DW-1:0]           reg_wdata,
  input logic [SEL_W*NLINES-1:0] evt_sel,
  input logic [NLINES-1:0]       hit,
  input logic [NLINES-1:0]       mask_q,
  input logic [NLINES-1:0]       status_q,
  input logic                    irq
);

  logic [NLINES-1:0] wbits, bad_sel;
  logic              set_wr, clr_wr, sts_rd;

  assign wbits  = reg_wdata[NLINES-1:0];
  assign set_wr = reg_wr_en && (reg_addr == AW'(OFF_EN_SET));
  assign clr_wr = reg_wr_en && (reg_addr == AW'(OFF_EN_CLR));
  assign sts_rd = reg_rd_en && (reg_addr == AW'(OFF_STATUS));

  always_comb begin
    for (int i = 0; i < NLINES; i++)
      bad_sel[i] = (evt_sel[i*SEL_W +: SEL_W] > 3'd4);
  end

  p_mask_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> ((mask_q & $past(wbits)) == $past(wbits)));

  p_mask_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((mask_q & $past(wbits)) == '0));

  p_no_hit_invalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit & bad_sel) == '0));

  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rd && (hit == '0)) |=> (status_q == '0));

  p_hit_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((status_q & $past(hit)) == $past(hit)));

  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  p_irq_needs_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status_q != '0));

endmodule

bind gpio_evt_bank gpio_evt_bank_chk #(.NLINES(NLINES), .DW(DW), .AW(AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr_en (reg_wr_en),
  .reg_rd_en (reg_rd_en),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .evt_sel   (evt_sel),
  .hit       (hit),
  .mask_q    (mask_q),
  .status_q  (status_q),
  .irq       (irq)
);

// File: tb/gpio_evt_bank_tb_top.sv
module gpio_evt_bank_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, rd_en;
  logic [7:0]    addr;
  logic [31:0]   wdata, rdata;
  logic [NL-1:0] line_in;
  logic [3*NL-1:0] evt_sel;
  logic          irq;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_evt_bank dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (wr_en),
    .reg_rd_en (rd_en),
    .reg_addr  (addr),
    .reg_wdata (wdata),
    .reg_rdata (rdata),
    .line_in   (line_in),
    .evt_sel   (evt_sel),
    .irq       (irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(posedge clk);
    #1 rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
  endtask

  task automatic set_sel(input int line, input logic [2:0] code);
    evt_sel[line*3 +: 3] = code;
  endtask

  function automatic logic expect_bit(input int code, input logic p, input logic c);
    // status after the clearing read (lines held at p) and one edge to c
    case (code)
      0: return p & ~c;
      1: return ~p & c;
      2: return p ^ c;
      3: return ~p | ~c;
      4: return p | c;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD*50000);
    n_errors++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    line_in = '0;
    evt_sel = {NL{3'd7}};
    idle(3);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    #1 check("R1 irq after reset", {31'b0, irq}, 32'h0);
    reg_read(8'h28, d); check("R1 mask after reset", d, 32'h0);
    reg_read(8'h2C, d); check("R1 status after reset", d, 32'h0);

    // R2 set and read back, unmapped offset reads zero
    reg_write(8'h20, 32'h0000_00F0);
    reg_read(8'h28, d); check("R2 mask set", d, 32'h0000_00F0);
    reg_write(8'h20, 32'h0F00_0000);
    reg_read(8'h28, d); check("R2 mask set accumulates", d, 32'h0F00_00F0);
    reg_read(8'h30, d); check("R2 unmapped read", d, 32'h0);

    // R3 clear
    reg_write(8'h24, 32'h0000_0030);
    reg_read(8'h28, d); check("R3 mask partial clear", d, 32'h0F00_00C0);
    reg_write(8'h24, 32'hFFFF_FFFF);
    reg_read(8'h28, d); check("R3 mask full clear", d, 32'h0);

    // R10 status latched while disabled, irq gated by mask
    set_sel(5, 3'd1);
    @(negedge clk) line_in[5] = 1'b1;
    idle(2);
    #1 check("R10 irq while disabled", {31'b0, irq}, 32'h0);
    reg_write(8'h20, 32'h0000_0020);
    #1 check("R10 irq after enable", {31'b0, irq}, 32'h1);
    reg_write(8'h24, 32'h0000_0020);
    #1 check("R10 irq after disable", {31'b0, irq}, 32'h0);
    reg_read(8'h2C, d); check("R10 status latched while disabled", d, 32'h0000_0020);
    set_sel(5, 3'd7);

    // R7 low level reappears after read, stops when released
    set_sel(0, 3'd3);
    idle(2);
    reg_read(8'h2C, d); check("R7 low level first read", d, 32'h1);
    reg_read(8'h2C, d); check("R7 low level reappears", d, 32'h1);
    @(negedge clk) line_in[0] = 1'b1;
    idle(2);
    reg_read(8'h2C, d); check("R7 level bit left from read cycle", d, 32'h1);
    reg_read(8'h2C, d); check("R7 level released", d, 32'h0);
    set_sel(0, 3'd7);

    // R9 event in the cycle of a clearing read is kept; R5 one-shot edge
    set_sel(1, 3'd1);
    idle(2);
    reg_read(8'h2C, d);
    @(negedge clk);
    line_in[1] = 1'b1; addr = 8'h2C; rd_en = 1'b1;
    #1 d = rdata;
    check("R9 read during edge returns old status", d, 32'h0);
    @(posedge clk);
    #1 rd_en = 1'b0;
    reg_read(8'h2C, d); check("R9 same-cycle event kept", d, 32'h2);
    reg_read(8'h2C, d); check("R5 edge recorded once", d, 32'h0);
    set_sel(1, 3'd7);

    // Sweep: every code against every pair of old and new levels
    for (int base = 0; base < 8; base++) begin
      for (int pv = 0; pv < 4; pv++) begin
        for (int cv = 0; cv < 4; cv++) begin
          logic [31:0] exp;
          logic [NL-1:0] pl, cl;
          for (int i = 0; i < NL; i++) begin
            pl[i] = 1'((pv >> (i % 2)) & 1);
            cl[i] = 1'((cv >> ((i / 2) % 2)) & 1);
            exp[i] = expect_bit((base + i) % 8, pl[i], cl[i]);
          end
          @(negedge clk);
          for (int i = 0; i < NL; i++) set_sel(i, 3'((base + i) % 8));
          line_in = pl;
          idle(2);
          reg_read(8'h2C, d);
          @(negedge clk) line_in = cl;
          reg_read(8'h2C, d);
          check("R4 R5 R6 R7 R8 sweep", d, exp);
        end
      end
    end

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule